// File: doc/BRIEF.md
# Switch-configured bus address decoder

This block turns a bus address into active-low chip selects for a board that sits on a shared backplane. Each select compares a chosen group of address lines against a match value set by a bank of switches. An open switch reads as 1 and a closed switch reads as 0, so a switch that is not fitted behaves as an open one and reads as 1.

A per-bit enable takes a line out of the compare. The decoder forces both the address side and the switch side of that bit low, so the bit can never cause a mismatch. Clearing the low enables therefore widens the window to a power-of-two block of ports or memory, and one set of inputs gives both the base and the block size.

There are three decoders, each built from identical 8-bit compare slices. The first is an 8-bit port decoder. The second is a 16-bit extended port decoder made of two cascaded slices. The third is a memory decoder that compares the address bits above a device's internal range, which is A23..A12 for a 4K part. The port selects are qualified by the I/O cycle strobe and the memory select by the memory cycle strobe. The block is purely combinational.

Top module: `bus_window_decoder`

## Requirements
- R1: `p8_sel_n` is 0 exactly when `io_cycle` is 1 and every bit of `addr[7:0]` that has its `p8_care` bit set equals the matching configuration bit; a single mismatch on a compared bit keeps it at 1.
- R2: The configuration bit is the inverse of the switch input: `*_sw_closed[i]` = 0 (switch open or not fitted) gives a configuration bit of 1, and `*_sw_closed[i]` = 1 gives 0.
- R3: With `p8_care` = 8'hFE and configuration 8'h8E, exactly ports 8EH and 8FH assert `p8_sel_n` over all 256 port addresses.
- R4: With `p8_care` = 8'hFC and configuration 8'h2C, exactly ports 2CH through 2FH assert `p8_sel_n`.
- R5: `p16_sel_n` is 0 exactly when `io_cycle` is 1 and every enabled bit of `addr[15:0]` matches its configuration bit; a mismatch in either byte slice keeps it at 1.
- R6: `mem_sel_n` compares `addr[23:12]` against the memory configuration under `mem_care`, and `addr[11:0]` never affects it. With configuration 12'h00F and all bits enabled, 0F000H and 0FFFFH assert it, while 0EFFFH, 10000H and 10F000H do not.
- R7: With `io_cycle` = 0 both port selects are 1, and with `mem_cycle` = 0 `mem_sel_n` is 1, whatever the address and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 24 | Bus address, A23..A0 |
| io_cycle | input | 1 | High during an I/O port cycle |
| mem_cycle | input | 1 | High during a memory cycle |
| p8_sw_closed | input | 8 | Switch states for the 8-bit port decoder (1 = closed) |
| p8_care | input | 8 | Per-bit compare enable for the 8-bit port decoder |
| p8_sel_n | output | 1 | Active-low select for the 8-bit port decoder |
| p16_sw_closed | input | 16 | Switch states for the 16-bit port decoder |
| p16_care | input | 16 | Per-bit compare enable for the 16-bit port decoder |
| p16_sel_n | output | 1 | Active-low select for the 16-bit port decoder |
| mem_sw_closed | input | 12 | Switch states for A23..A12 of the memory decoder |
| mem_care | input | 12 | Per-bit compare enable for the memory decoder |
| mem_sel_n | output | 1 | Active-low memory window select |

## Verification
A port select and the memory select can both be low at the same time. This happens only when both cycle qualifiers are high and the address falls inside a port window and the memory window at once. The bench provokes this by raising `io_cycle` and `mem_cycle` together at an address that matches all three configurations. It then checks that each select follows its own compare alone, and that with a single qualifier only the matching select can assert. Full sweeps of the 256 port addresses confirm that exactly the expected number of addresses select.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int SLICE_W = 8;

  // Match test for one slice: disabled bits are driven low on both sides,
  // so they can never produce a mismatch.
  function automatic logic slice_equal(input logic [SLICE_W-1:0] a,
                                       input logic [SLICE_W-1:0] cfg,
                                       input logic [SLICE_W-1:0] care);
    logic [SLICE_W-1:0] a_side;
    logic [SLICE_W-1:0] c_side;
    a_side = a & care;
    c_side = cfg & care;
    return a_side == c_side;
  endfunction

  // A closed switch pulls its line low; an open or unfitted one reads high.
  function automatic logic sw_level(input logic closed);
    return ~closed;
  endfunction
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import bwd_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] cfg,
  input  logic [SLICE_W-1:0] care,
  output logic               eq_n
);
  assign eq_n = ~slice_equal(a, cfg, care);
endmodule

// File: rtl/wide_match.sv
module wide_match
  import bwd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] sw_closed,
  input  logic [W-1:0] care,
  output logic         eq_n
);
  localparam int NS    = (W + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W = NS * SLICE_W;

  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] cfg_pad;
  logic [PAD_W-1:0] care_pad;
  logic [NS-1:0]    slice_eq_n;

  always_comb begin
    a_pad    = '0;
    cfg_pad  = '0;
    care_pad = '0;
    a_pad[W-1:0] = a;
    for (int i = 0; i < W; i++) begin
      cfg_pad[i] = sw_level(sw_closed[i]);
    end
    care_pad[W-1:0] = care;
  end

  for (genvar s = 0; s < NS; s++) begin : g_slice
    cmp_slice u_slice (
      .a    (a_pad[s*SLICE_W +: SLICE_W]),
      .cfg  (cfg_pad[s*SLICE_W +: SLICE_W]),
      .care (care_pad[s*SLICE_W +: SLICE_W]),
      .eq_n (slice_eq_n[s])
    );
  end

  // Cascade: any slice reporting a mismatch blocks the whole match.
  assign eq_n = |slice_eq_n;
endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder #(
  parameter int ADDR_W     = 24,
  parameter int PORT8_W    = 8,
  parameter int PORT16_W   = 16,
  parameter int DEV_ADDR_W = 12,
  localparam int MEM_CMP_W = ADDR_W - DEV_ADDR_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 io_cycle,
  input  logic                 mem_cycle,
  input  logic [PORT8_W-1:0]   p8_sw_closed,
  input  logic [PORT8_W-1:0]   p8_care,
  output logic                 p8_sel_n,
  input  logic [PORT16_W-1:0]  p16_sw_closed,
  input  logic [PORT16_W-1:0]  p16_care,
  output logic                 p16_sel_n,
  input  logic [MEM_CMP_W-1:0] mem_sw_closed,
  input  logic [MEM_CMP_W-1:0] mem_care,
  output logic                 mem_sel_n
);
  // Raw compare results, brought out by name for the checker.
  logic p8_eq_n;
  logic p16_eq_n;
  logic mem_eq_n;

  wide_match #(.W(PORT8_W)) u_p8 (
    .a         (addr[PORT8_W-1:0]),
    .sw_closed (p8_sw_closed),
    .care      (p8_care),
    .eq_n      (p8_eq_n)
  );

  wide_match #(.W(PORT16_W)) u_p16 (
    .a         (addr[PORT16_W-1:0]),
    .sw_closed (p16_sw_closed),
    .care      (p16_care),
    .eq_n      (p16_eq_n)
  );

  wide_match #(.W(MEM_CMP_W)) u_mem (
    .a         (addr[ADDR_W-1:DEV_ADDR_W]),
    .sw_closed (mem_sw_closed),
    .care      (mem_care),
    .eq_n      (mem_eq_n)
  );

  // Cycle qualification keeps port and memory spaces apart.
  assign p8_sel_n  = p8_eq_n  | ~io_cycle;
  assign p16_sel_n = p16_eq_n | ~io_cycle;
  assign mem_sel_n = mem_eq_n | ~mem_cycle;
endmodule

// File: rtl/bus_window_decoder_chk.sv
module bus_window_decoder_chk #(
  parameter int ADDR_W     = 24,
  parameter int PORT8_W    = 8,
  parameter int PORT16_W   = 16,
  parameter int DEV_ADDR_W = 12,
  localparam int MEM_CMP_W = ADDR_W - DEV_ADDR_W
) (
  input logic [ADDR_W-1:0]    addr,
  input logic                 io_cycle,
  input logic                 mem_cycle,
  input logic [PORT8_W-1:0]   p8_sw_closed,
  input logic [PORT8_W-1:0]   p8_care,
  input logic                 p8_sel_n,
  input logic [PORT16_W-1:0]  p16_sw_closed,
  input logic [PORT16_W-1:0]  p16_care,
  input logic                 p16_sel_n,
  input logic [MEM_CMP_W-1:0] mem_sw_closed,
  input logic [MEM_CMP_W-1:0] mem_care,
  input logic                 mem_sel_n
);
  logic p8_ok;
  logic p16_ok;
  logic mem_ok;

  // A closed switch means 0, so an address bit equal to the closed flag is a mismatch.
  always_comb begin
    p8_ok = 1'b1;
    for (int i = 0; i < PORT8_W; i++)
      if (p8_care[i] && (addr[i] == p8_sw_closed[i])) p8_ok = 1'b0;
    p16_ok = 1'b1;
    for (int i = 0; i < PORT16_W; i++)
      if (p16_care[i] && (addr[i] == p16_sw_closed[i])) p16_ok = 1'b0;
    mem_ok = 1'b1;
    for (int i = 0; i < MEM_CMP_W; i++)
      if (mem_care[i] && (addr[DEV_ADDR_W+i] == mem_sw_closed[i])) mem_ok = 1'b0;
  end

  always_comb begin
    p_port8_only_on_match_r1: assert (p8_sel_n || p8_ok)
      else $error("p8 select low on mismatch");
    p_port8_fires_on_match_r1: assert (!(io_cycle && p8_ok) || !p8_sel_n)
      else $error("p8 select high on match");
    p_port16_only_on_match_r5: assert (p16_sel_n || p16_ok)
      else $error("p16 select low on mismatch");
    p_mem_only_on_match_r6: assert (mem_sel_n || mem_ok)
      else $error("mem select low outside window");
    p_port_qual_r7: assert (io_cycle || (p8_sel_n && p16_sel_n))
      else $error("port select without io cycle");
    p_mem_qual_r7: assert (mem_cycle || mem_sel_n)
      else $error("mem select without mem cycle");
  end
endmodule

bind bus_window_decoder bus_window_decoder_chk #(
  .ADDR_W(ADDR_W), .PORT8_W(PORT8_W), .PORT16_W(PORT16_W), .DEV_ADDR_W(DEV_ADDR_W)
) u_chk (
  .addr(addr), .io_cycle(io_cycle), .mem_cycle(mem_cycle),
  .p8_sw_closed(p8_sw_closed), .p8_care(p8_care), .p8_sel_n(p8_sel_n),
  .p16_sw_closed(p16_sw_closed), .p16_care(p16_care), .p16_sel_n(p16_sel_n),
  .mem_sw_closed(mem_sw_closed), .mem_care(mem_care), .mem_sel_n(mem_sel_n)
);

// File: tb/bus_window_decoder_bench.sv
`timescale 1ns/1ps
module bus_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        io_cycle = 1'b0;
  logic        mem_cycle = 1'b0;
  logic [7:0]  p8_sw_closed = '0;
  logic [7:0]  p8_care = '0;
  logic        p8_sel_n;
  logic [15:0] p16_sw_closed = '0;
  logic [15:0] p16_care = '0;
  logic        p16_sel_n;
  logic [11:0] mem_sw_closed = '0;
  logic [11:0] mem_care = '0;
  logic        mem_sel_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_window_decoder u_bus_window_decoder (.*);

  // Reference: walk the bits as integers; a disabled bit is skipped,
  // an enabled bit matches when the address bit differs from the closed flag.
  function automatic int ref_sel_n(int a, int closed, int care, int w, bit qual);
    for (int k = 0; k < w; k++) begin
      if (((care >> k) & 1) == 1) begin
        int want = 1 - ((closed >> k) & 1);
        if (((a >> k) & 1) != want) return 1;
      end
    end
    return qual ? 0 : 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%0d expected=%0d", tag, what, addr, act, exp);
    end
  endtask

  // Drive after a rising edge, compare all three selects at the falling edge.
  task automatic step(string tag, int a, bit io, bit mem);
    @(posedge clk);
    addr = a[23:0]; io_cycle = io; mem_cycle = mem;
    @(negedge clk);
    check(tag, "p8", int'(p8_sel_n), ref_sel_n(a & 'hFF, p8_sw_closed, p8_care, 8, io));
    check(tag, "p16", int'(p16_sel_n), ref_sel_n(a & 'hFFFF, p16_sw_closed, p16_care, 16, io));
    check(tag, "mem", int'(mem_sel_n), ref_sel_n(a >> 12, mem_sw_closed, mem_care, 12, mem));
  endtask

  task automatic sweep8(string tag, int exp_hits);
    int hits = 0;
    for (int p = 0; p < 256; p++) begin
      step(tag, p, 1'b1, 1'b0);
      if (!p8_sel_n) hits++;
    end
    check(tag, "hit count", hits, exp_hits);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7: idle with no qualifier, all selects high
    @(negedge clk);
    check("R7", "idle p8", int'(p8_sel_n), 1);
    check("R7", "idle p16", int'(p16_sel_n), 1);
    check("R7", "idle mem", int'(mem_sel_n), 1);

    // R2: all switches open -> config all ones, only port FFH
    p8_sw_closed = 8'h00; p8_care = 8'hFF;
    sweep8("R2", 1);
    step("R2", 'hFF, 1'b1, 1'b0);
    check("R2", "FFH selects", int'(p8_sel_n), 0);

    // R1: full compare at A5H, every single-bit neighbour misses
    p8_sw_closed = ~8'hA5;
    sweep8("R1", 1);
    for (int b = 0; b < 8; b++) begin
      step("R1", 'hA5 ^ (1 << b), 1'b1, 1'b0);
      check("R1", "one-bit miss", int'(p8_sel_n), 1);
    end

    // R3: 1000111x
    p8_sw_closed = ~8'h8E; p8_care = 8'hFE;
    sweep8("R3", 2);
    step("R3", 'h8E, 1'b1, 1'b0); check("R3", "8EH", int'(p8_sel_n), 0);
    step("R3", 'h8F, 1'b1, 1'b0); check("R3", "8FH", int'(p8_sel_n), 0);
    step("R3", 'h8D, 1'b1, 1'b0); check("R3", "8DH", int'(p8_sel_n), 1);

    // R4: 001011xx
    p8_sw_closed = ~8'h2C; p8_care = 8'hFC;
    sweep8("R4", 4);
    step("R4", 'h2B, 1'b1, 1'b0); check("R4", "2BH", int'(p8_sel_n), 1);
    step("R4", 'h30, 1'b1, 1'b0); check("R4", "30H", int'(p8_sel_n), 1);

    // R5: 16-bit window 12C0..12CF, mismatch in either byte
    p16_sw_closed = ~16'h12C0; p16_care = 16'hFFF0;
    step("R5", 'h12C0, 1'b1, 1'b0); check("R5", "base", int'(p16_sel_n), 0);
    step("R5", 'h12CF, 1'b1, 1'b0); check("R5", "top", int'(p16_sel_n), 0);
    step("R5", 'h12D0, 1'b1, 1'b0); check("R5", "low byte miss", int'(p16_sel_n), 1);
    step("R5", 'h13C0, 1'b1, 1'b0); check("R5", "high byte miss", int'(p16_sel_n), 1);
    step("R5", 'h02C5, 1'b1, 1'b0); check("R5", "high byte miss2", int'(p16_sel_n), 1);

    // R6: 4K window at 0F000H
    mem_sw_closed = ~12'h00F; mem_care = 12'hFFF;
    step("R6", 'h0EFFF, 1'b0, 1'b1); check("R6", "0EFFFH", int'(mem_sel_n), 1);
    step("R6", 'h0F000, 1'b0, 1'b1); check("R6", "0F000H", int'(mem_sel_n), 0);
    step("R6", 'h0F7A3, 1'b0, 1'b1); check("R6", "inside", int'(mem_sel_n), 0);
    step("R6", 'h0FFFF, 1'b0, 1'b1); check("R6", "0FFFFH", int'(mem_sel_n), 0);
    step("R6", 'h10000, 1'b0, 1'b1); check("R6", "10000H", int'(mem_sel_n), 1);
    step("R6", 'h10F000, 1'b0, 1'b1); check("R6", "10F000H", int'(mem_sel_n), 1);

    // R7: qualifiers keep spaces apart; then both at once
    p8_sw_closed = ~8'h00; p8_care = 8'hFF;
    p16_sw_closed = ~16'hF000; p16_care = 16'hFFFF;
    step("R7", 'h0F000, 1'b1, 1'b0);
    check("R7", "mem blocked by io", int'(mem_sel_n), 1);
    check("R7", "p8 on io", int'(p8_sel_n), 0);
    step("R7", 'h0F000, 1'b0, 1'b1);
    check("R7", "p8 blocked by mem", int'(p8_sel_n), 1);
    check("R7", "p16 blocked by mem", int'(p16_sel_n), 1);
    check("R7", "mem on mem", int'(mem_sel_n), 0);
    step("R7", 'h0F000, 1'b1, 1'b1);
    check("R7", "both p16", int'(p16_sel_n), 0);
    check("R7", "both mem", int'(mem_sel_n), 0);
    step("R7", 'h0F000, 1'b0, 1'b0);
    check("R7", "none", int'(p8_sel_n & p16_sel_n & mem_sel_n), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule